// File: doc/BRIEF.md
# Memory Port Activity and Energy Monitor

This block watches the request/response link between an interconnect and an SRAM slave. It drives nothing on that link. Each clock cycle is placed in one of three activity classes: a read access, a write access or an idle cycle. Each class has its own counter. A running energy total adds a fixed unit cost each time a counter advances.

Activity is taken from slave responses. The command of every accepted request goes into a small in-order queue. Each valid response retires the oldest entry, and that entry decides whether the cycle was a read or a write. For slaves that post writes without answering them, a build option counts a write when the request is accepted instead.

The unit costs are parameters. By default they are derived from the memory depth and the word width. The counters and the energy total can be read at any time, and a synchronous clear restarts the measurement.

Top module: `mem_energy_monitor`

## Requirements
- R1: While reset is asserted, and after it, before the first counted cycle, all three counters and `energy_total` read 0 and `pstate` reads the idle code 0. The other codes are read = 1 and write = 2.
- R2: A request is accepted when `link_accept` is high and `link_cmd` is 1 (write) or 2 (read). Code 0 and code 3 are not requests. A cycle in which `link_resp` is 1 and the oldest outstanding request is a read is classed as Read: `cnt_read` advances and `pstate` shows 1 one cycle later.
- R3: With `POSTED_WR` = 0, accepted writes are queued in order with reads. A response code of 1 that retires a queued write classes the cycle as Write.
- R4: With `POSTED_WR` = 0, a cycle with `link_resp` other than 1 is Idle. Codes 0, 2 and 3 retire nothing.
- R5: A response code of 1 while nothing is outstanding classes the cycle as Idle and has no later effect.
- R6: With `POSTED_WR` = 1, writes are not queued. An accepted write classes its own cycle as Write, unless a read response is retired in that cycle. In that case the write is held and counted in the next cycle that retires no response. Held writes drain one per cycle.
- R7: In every counted cycle exactly one counter advances. Until a counter saturates, the sum of the three counters equals the number of cycles since reset or the last clear.
- R8: `energy_total` equals cnt_read*READ_COST + cnt_write*WRITE_COST + cnt_idle*IDLE_COST, and it never decreases except on clear.
- R9: A counter stops at 2^CNT_W-1. A saturated counter neither wraps nor adds energy.
- R10: `clear` takes priority over counting. It zeroes the counters and the energy total, sets `pstate` to idle and discards outstanding and held requests, so a later response with code 1 counts as Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of the measurement |
| link_cmd | input | 2 | Observed request command: 0 none, 1 write, 2 read |
| link_accept | input | 1 | Observed slave acceptance of the request |
| link_resp | input | 2 | Observed response code: 1 means valid |
| pstate | output | 2 | Class of the last counted cycle: 0 idle, 1 read, 2 write |
| cnt_read | output | CNT_W | Read access count |
| cnt_write | output | CNT_W | Write access count |
| cnt_idle | output | CNT_W | Idle cycle count |
| energy_total | output | ACC_W | Weighted energy total |

## Verification
The hardest cases to reach are those where a posted write collides with a read response, and where a response arrives after its request has been flushed by a clear. Both depend on the exact cycle in which acceptance and response line up. The stimulus accepts a read, then in the very next cycle accepts a write while returning the read's response. It also issues a clear in the same cycle as a valid response to a still-outstanding read. A third instance with 3-bit counters reaches saturation within a few dozen cycles, so the stop-without-energy behaviour is observed directly at the ports.

// File: rtl/mem_energy_monitor.sv
module mem_energy_monitor #(
  parameter int          DEPTH_WORDS = 1024,
  parameter int          WORD_BITS   = 32,
  parameter int          CNT_W       = 32,
  parameter int          ACC_W       = 48,
  parameter int          QDEPTH      = 8,
  parameter bit          POSTED_WR   = 1'b0,
  parameter int unsigned READ_COST   = WORD_BITS * 3 + $clog2(DEPTH_WORDS) * 2,
  parameter int unsigned WRITE_COST  = WORD_BITS * 4 + $clog2(DEPTH_WORDS) * 2,
  parameter int unsigned IDLE_COST   = (WORD_BITS * DEPTH_WORDS) / 4096 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [1:0]       link_cmd,
  input  logic             link_accept,
  input  logic [1:0]       link_resp,
  output logic [1:0]       pstate,
  output logic [CNT_W-1:0] cnt_read,
  output logic [CNT_W-1:0] cnt_write,
  output logic [CNT_W-1:0] cnt_idle,
  output logic [ACC_W-1:0] energy_total
);
  localparam logic [1:0] CMD_WR = 2'd1, CMD_RD = 2'd2, RESP_OK = 2'd1;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_READ = 2'd1, ST_WRITE = 2'd2;
  localparam int QW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam logic [QW-1:0] QLAST = QW'(QDEPTH - 1);
  localparam logic [QW:0] QFULL = (QW + 1)'(QDEPTH);
  localparam logic [QW:0] PMAX = '1;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [ACC_W-1:0] C_RD = ACC_W'(READ_COST);
  localparam logic [ACC_W-1:0] C_WR = ACC_W'(WRITE_COST);
  localparam logic [ACC_W-1:0] C_ID = ACC_W'(IDLE_COST);

  logic [QDEPTH-1:0] q_isrd;
  logic [QW-1:0]     q_wp, q_rp;
  logic [QW:0]       q_cnt, pend;
  logic [1:0]        cls;
  logic [CNT_W-1:0]  cnt [3];
  logic              advance;
  logic [ACC_W-1:0]  add;
  logic [ACC_W:0]    esum;

  wire acc_rd   = link_accept && link_cmd == CMD_RD;
  wire acc_wr   = link_accept && link_cmd == CMD_WR;
  wire q_empty  = q_cnt == '0;
  wire resp_hit = link_resp == RESP_OK && !q_empty;
  wire head_rd  = q_isrd[q_rp];
  wire push     = (acc_rd || (acc_wr && !POSTED_WR)) && q_cnt != QFULL;
  wire pop      = resp_hit;
  wire post_now = POSTED_WR && !resp_hit && (acc_wr || pend != '0);

  always_comb begin
    cls = ST_IDLE;
    if (resp_hit)      cls = head_rd ? ST_READ : ST_WRITE;
    else if (post_now) cls = ST_WRITE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wp <= '0; q_rp <= '0; q_cnt <= '0; q_isrd <= '0;
    end else if (clear) begin
      q_wp <= '0; q_rp <= '0; q_cnt <= '0;
    end else begin
      if (push) begin
        q_isrd[q_wp] <= acc_rd;
        q_wp <= (q_wp == QLAST) ? '0 : q_wp + 1'b1;
      end
      if (pop) q_rp <= (q_rp == QLAST) ? '0 : q_rp + 1'b1;
      case ({push, pop})
        2'b10:   q_cnt <= q_cnt + 1'b1;
        2'b01:   q_cnt <= q_cnt - 1'b1;
        default: q_cnt <= q_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend <= '0;
    else if (clear)            pend <= '0;
    else if (POSTED_WR) begin
      case ({acc_wr, post_now})
        2'b10:   if (pend != PMAX) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt[g] <= '0;
      else if (clear)                            cnt[g] <= '0;
      else if (cls == 2'(g) && cnt[g] != CMAX)   cnt[g] <= cnt[g] + 1'b1;
    end
  end

  always_comb begin
    case (cls)
      ST_READ:  begin advance = cnt[1] != CMAX; add = C_RD; end
      ST_WRITE: begin advance = cnt[2] != CMAX; add = C_WR; end
      default:  begin advance = cnt[0] != CMAX; add = C_ID; end
    endcase
  end

  assign esum = {1'b0, energy_total} + {1'b0, add};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        energy_total <= '0;
    else if (clear)    energy_total <= '0;
    else if (advance)  energy_total <= esum[ACC_W] ? '1 : esum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pstate <= ST_IDLE;
    else if (clear) pstate <= ST_IDLE;
    else            pstate <= cls;
  end

  assign cnt_idle  = cnt[0];
  assign cnt_read  = cnt[1];
  assign cnt_write = cnt[2];
endmodule

// File: rtl/mem_energy_monitor_chk.sv
module mem_energy_monitor_chk #(
  parameter int CNT_W     = 32,
  parameter int ACC_W     = 48,
  parameter bit POSTED_WR = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic [1:0]       link_resp,
  input logic [1:0]       pstate,
  input logic [CNT_W-1:0] cnt_read,
  input logic [CNT_W-1:0] cnt_write,
  input logic [CNT_W-1:0] cnt_idle,
  input logic [ACC_W-1:0] energy_total
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic live;
  wire [CNT_W+1:0] total = (CNT_W + 2)'(cnt_read) + (CNT_W + 2)'(cnt_write) + (CNT_W + 2)'(cnt_idle);
  wire any_sat = cnt_read == CMAX || cnt_write == CMAX || cnt_idle == CMAX;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= !clear;

  assert_clear_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_read == '0 && cnt_write == '0 && cnt_idle == '0 && energy_total == '0 && pstate == 2'd0));

  assert_one_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(any_sat)) |-> total == $past(total) + 1'b1);

  assert_no_resp_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!POSTED_WR && link_resp != 2'd1) |=> pstate == 2'd0);

  assert_energy_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> energy_total >= $past(energy_total));

  assert_read_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_read == CMAX && !clear) |=> cnt_read == CMAX);

  assert_idle_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_idle == CMAX && !clear) |=> cnt_idle == CMAX);

  assert_state_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pstate != 2'd3);
endmodule

bind mem_energy_monitor mem_energy_monitor_chk #(.CNT_W(CNT_W), .ACC_W(ACC_W), .POSTED_WR(POSTED_WR)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .link_resp(link_resp), .pstate(pstate),
  .cnt_read(cnt_read), .cnt_write(cnt_write), .cnt_idle(cnt_idle), .energy_total(energy_total)
);

// File: tb/tb_mem_energy_monitor.sv
module tb_mem_energy_monitor;
  localparam int RC = 7, WC = 11, IC = 2;
  localparam int SAT = 7;

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, link_accept = 1'b0;
  logic [1:0] link_cmd = 2'd0, link_resp = 2'd0;
  logic [1:0] st_n, st_p, st_s;
  logic [31:0] rd_n, wr_n, id_n, rd_p, wr_p, id_p;
  logic [2:0]  rd_s, wr_s, id_s;
  logic [47:0] en_n, en_p, en_s;

  always #5 clk = ~clk;

  mem_energy_monitor #(.POSTED_WR(1'b0), .READ_COST(RC), .WRITE_COST(WC), .IDLE_COST(IC)) dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .link_cmd(link_cmd), .link_accept(link_accept),
    .link_resp(link_resp), .pstate(st_n), .cnt_read(rd_n), .cnt_write(wr_n), .cnt_idle(id_n),
    .energy_total(en_n));
  mem_energy_monitor #(.POSTED_WR(1'b1), .READ_COST(RC), .WRITE_COST(WC), .IDLE_COST(IC)) dut_p (
    .clk(clk), .rst_n(rst_n), .clear(clear), .link_cmd(link_cmd), .link_accept(link_accept),
    .link_resp(link_resp), .pstate(st_p), .cnt_read(rd_p), .cnt_write(wr_p), .cnt_idle(id_p),
    .energy_total(en_p));
  mem_energy_monitor #(.POSTED_WR(1'b0), .CNT_W(3), .READ_COST(RC), .WRITE_COST(WC), .IDLE_COST(IC)) dut_s (
    .clk(clk), .rst_n(rst_n), .clear(clear), .link_cmd(link_cmd), .link_accept(link_accept),
    .link_resp(link_resp), .pstate(st_s), .cnt_read(rd_s), .cnt_write(wr_s), .cnt_idle(id_s),
    .energy_total(en_s));

  typedef struct { bit clr; int cn; int cp; string tag; } item_t;
  item_t exp_q[$];
  bit qn[$], qp[$];
  int pend = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  int e_n[3], e_p[3], e_s[3];
  longint x_n = 0, x_p = 0, x_s = 0;
  int cyc = 0;
  int cost[3] = '{IC, RC, WC};

  task automatic check(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(logic [1:0] cmd, logic acc, logic [1:0] resp, logic clr, string tag);
    item_t it;
    bit ard, awr, hit;
    link_cmd = cmd; link_accept = acc; link_resp = resp; clear = clr;
    ard = acc && cmd == 2'd2;
    awr = acc && cmd == 2'd1;
    it.clr = clr; it.tag = tag; it.cn = 0; it.cp = 0;
    if (clr) begin
      qn.delete(); qp.delete(); pend = 0;
    end else begin
      hit = resp == 2'd1 && qn.size() > 0;
      if (hit) begin it.cn = qn[0] ? 1 : 2; void'(qn.pop_front()); end
      if (ard || awr) qn.push_back(ard);
      hit = resp == 2'd1 && qp.size() > 0;
      if (hit) begin
        it.cp = 1; void'(qp.pop_front());
        if (awr) pend++;
      end else if (awr || pend > 0) begin
        it.cp = 2;
        if (!awr) pend--;
      end
      if (ard) qp.push_back(1'b1);
    end
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        if (it.clr) begin
          for (int k = 0; k < 3; k++) begin e_n[k] = 0; e_p[k] = 0; e_s[k] = 0; end
          x_n = 0; x_p = 0; x_s = 0; cyc = 0;
        end else begin
          e_n[it.cn]++; x_n += cost[it.cn];
          e_p[it.cp]++; x_p += cost[it.cp];
          if (e_s[it.cn] < SAT) begin e_s[it.cn]++; x_s += cost[it.cn]; end
          cyc++;
        end
        check(st_n == 2'(it.cn), it.tag, st_n, it.cn);
        check(rd_n == 32'(e_n[1]) && wr_n == 32'(e_n[2]) && id_n == 32'(e_n[0]), "R7 counters",
              {rd_n[15:0], wr_n[15:0], id_n[15:0]}, {16'(e_n[1]), 16'(e_n[2]), 16'(e_n[0])});
        check(int'(rd_n + wr_n + id_n) == cyc, "R7 sum", rd_n + wr_n + id_n, cyc);
        check(en_n == 48'(x_n), "R8 energy", en_n, x_n);
        check(st_p == 2'(it.cp), "R6 posted state", st_p, it.cp);
        check(rd_p == 32'(e_p[1]) && wr_p == 32'(e_p[2]) && id_p == 32'(e_p[0]), "R6 posted counters",
              {rd_p[15:0], wr_p[15:0], id_p[15:0]}, {16'(e_p[1]), 16'(e_p[2]), 16'(e_p[0])});
        check(en_p == 48'(x_p), "R8 posted energy", en_p, x_p);
        check(rd_s == 3'(e_s[1]) && wr_s == 3'(e_s[2]) && id_s == 3'(e_s[0]), "R9 saturated counters",
              {rd_s, wr_s, id_s}, {3'(e_s[1]), 3'(e_s[2]), 3'(e_s[0])});
        check(en_s == 48'(x_s), "R9 saturated energy", en_s, x_s);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #23;
    check(rd_n == 0 && wr_n == 0 && id_n == 0 && en_n == 0, "R1 reset counters", rd_n + wr_n + id_n + en_n, 0);
    check(st_n == 2'd0 && st_p == 2'd0, "R1 reset state", st_n, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(2'd0, 1'b0, 2'd0, 1'b0, "R4 idle");
    step(2'd2, 1'b1, 2'd0, 1'b0, "R2 read accepted");
    step(2'd0, 1'b0, 2'd0, 1'b0, "R4 waiting");
    step(2'd0, 1'b0, 2'd1, 1'b0, "R2 read response");
    step(2'd1, 1'b1, 2'd0, 1'b0, "R6 write accepted");
    step(2'd0, 1'b0, 2'd1, 1'b0, "R3 write response");
    step(2'd0, 1'b0, 2'd1, 1'b0, "R5 spurious response");
    step(2'd2, 1'b1, 2'd0, 1'b0, "R2 read accepted");
    step(2'd0, 1'b0, 2'd2, 1'b0, "R4 non-valid code");
    step(2'd0, 1'b0, 2'd3, 1'b0, "R4 non-valid code");
    step(2'd0, 1'b0, 2'd1, 1'b0, "R2 read after bad codes");
    step(2'd2, 1'b1, 2'd0, 1'b0, "R2 rd");
    step(2'd1, 1'b1, 2'd0, 1'b0, "R3 wr");
    step(2'd2, 1'b1, 2'd0, 1'b0, "R2 rd");
    step(2'd0, 1'b0, 2'd1, 1'b0, "R2 in-order read");
    step(2'd0, 1'b0, 2'd1, 1'b0, "R3 in-order write");
    step(2'd0, 1'b0, 2'd1, 1'b0, "R2 in-order read");
    step(2'd2, 1'b1, 2'd0, 1'b0, "R2 rd");
    step(2'd1, 1'b1, 2'd1, 1'b0, "R6 collision");
    step(2'd0, 1'b0, 2'd0, 1'b0, "R6 deferred write");
    step(2'd0, 1'b0, 2'd1, 1'b0, "R3 queued write");
    step(2'd2, 1'b0, 2'd0, 1'b0, "R2 not accepted");
    step(2'd3, 1'b1, 2'd0, 1'b0, "R2 code three");
    step(2'd0, 1'b0, 2'd1, 1'b0, "R5 nothing outstanding");
    step(2'd2, 1'b1, 2'd0, 1'b0, "R2 rd");
    step(2'd2, 1'b1, 2'd0, 1'b0, "R2 rd");
    step(2'd0, 1'b0, 2'd1, 1'b1, "R10 clear wins");
    step(2'd0, 1'b0, 2'd1, 1'b0, "R10 flushed");
    for (int i = 0; i < 12; i++) step(2'd0, 1'b0, 2'd0, 1'b0, "R9 idle run");
    for (int i = 0; i < 9; i++) begin
      step(2'd2, 1'b1, 2'd0, 1'b0, "R9 rd");
      step(2'd0, 1'b0, 2'd1, 1'b0, "R9 read past saturation");
    end
    step(2'd0, 1'b0, 2'd0, 1'b1, "R10 final clear");
    step(2'd0, 1'b0, 2'd0, 1'b0, "R4 idle after clear");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule